// File: doc/BRIEF.md
# Interrupt Mask, Status and Tick Timer Controller

This block sits on a simple 64-bit register bus next to a processor. It keeps an interrupt mask and an interrupt status word, and raises a single CPU interrupt line whenever any status bit is set under a mask bit that is also set. Software can load the status word outright, or clear chosen bits through either of two clear addresses.

A second part of the block counts time. A 64-bit counter advances by a fixed step of 1000 on every tick strobe, and software may read or overwrite it. A compare register sits beside it. A separate timer interrupt line rises once the counter exceeds the compare value, but only while one chosen bit of the interrupt mask (bit 50) is enabled.

Several other addresses give fixed answers. A memory configuration word reads as a constant, and a scratch register returns what was last written. Reads at any other offset return zero, and writes to those offsets have no effect.

Top module: `irq_timer_ctl`

## Requirements
- R1: While rst_ni is low, and after it is released, the mask, status, counter, compare and scratch registers all read zero, and both interrupt outputs are low.
- R2: Offset 0x10000 holds a 64-bit mask. A write stores the data, and a read returns the stored value.
- R3: A write to offset 0x10020 replaces the whole status word with the written data and does not OR into the old value. A read of offset 0x10030 returns the status word.
- R4: A write to offset 0x10028 or to offset 0x10030 clears each status bit whose bit in the write data is 1. All other status bits keep their value.
- R5: cpu_irq_o is high exactly when (status AND mask) is nonzero. After a write to the mask or to the status word, it takes its new value in the same cycle that the register updates.
- R6: Offset 0x20000 is a 64-bit counter that can be read and written. Each cycle with tick_i high adds 1000 to it, modulo 2^64.
- R7: If a counter write and a tick fall in the same cycle, the counter takes the written value, and that tick adds nothing.
- R8: Offset 0x30000 is a 64-bit compare register that can be read and written. timer_irq_o is high exactly when mask bit 50 is 1 and the counter is greater than the compare value, comparing both as unsigned numbers.
- R9: A read of offset 0x20 returns 0x0000000080010000. A write to offset 0x20 changes no readable state.
- R10: Offset 0x10018 is a 64-bit scratch register. A read returns the value last written to it.
- R11: Reads of any unmapped offset return zero, and this includes the write-only offsets 0x10020 and 0x10028. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 20 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data for bus_addr_i, combinational |
| tick_i | input | 1 | Counter advance strobe, one step per high cycle |
| cpu_irq_o | output | 1 | Masked status interrupt |
| timer_irq_o | output | 1 | Timer interrupt |

## Verification
All registers update on the clock edge that samples the write strobe or the tick strobe. Read data and both interrupt outputs are combinational from those registers, so every result is due one edge after its stimulus. The bench drives inputs on the falling edge. It reads the effect of a write or tick on the next falling edge, a half period after the rising edge that captured it, and it settles read data for 1 ns after setting the address before sampling. The timer threshold is approached one tick at a time, so the cycle in which the counter goes past the compare value is checked, and so is the case where the two are equal.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam logic [31:0] OFS_MEMCFG  = 32'h0000_0020;
  localparam logic [31:0] OFS_MASK    = 32'h0001_0000;
  localparam logic [31:0] OFS_SCRATCH = 32'h0001_0018;
  localparam logic [31:0] OFS_SET     = 32'h0001_0020;
  localparam logic [31:0] OFS_CLR     = 32'h0001_0028;
  localparam logic [31:0] OFS_STATUS  = 32'h0001_0030;
  localparam logic [31:0] OFS_COUNT   = 32'h0002_0000;
  localparam logic [31:0] OFS_CMP     = 32'h0003_0000;
  localparam logic [31:0] MEMCFG_WORD = 32'h8001_0000;
endpackage

// File: rtl/itc_status_unit.sv
module itc_status_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mask_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i;
      if (wr_set_i)      status_q <= wdata_i;
      else if (wr_clr_i) status_q <= status_q & ~wdata_i;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_q);

  // R3: full replacement, no OR with old value
  a_r3_set_replaces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> status_q == $past(wdata_i));
  // R4: clear only the bits given
  a_r4_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_set_i) |=> status_q == ($past(status_q) & ~$past(wdata_i)));
  // R2: mask holds without a write
  a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_q));
endmodule

// File: rtl/itc_counter_unit.sv
module itc_counter_unit #(
  parameter int          DATA_W = 64,
  parameter int unsigned STEP   = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_cnt_i,
  input  logic              wr_cmp_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gate_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STEP);

  logic [DATA_W-1:0] cnt_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      // software write wins over a coincident tick
      if (wr_cnt_i)    cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= cnt_q + STEP_W;
      if (wr_cmp_i) cmp_q <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = gate_i && (cnt_q > cmp_q);

  // R6: one step per tick
  a_r6_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i) |=> cnt_q == $past(cnt_q) + STEP_W);
  // R6: counter idle without tick or write
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> $stable(cnt_q));
  // R7: write beats tick
  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_q == $past(wdata_i));
  // R8: timer line needs the enabling mask bit
  a_r8_timer_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gate_i);
endmodule

// File: rtl/itc_read_mux.sv
module itc_read_mux
  import irq_timer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] scratch_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(OFS_MEMCFG))  rdata_o = DATA_W'(MEMCFG_WORD);
    else if (addr_i == ADDR_W'(OFS_MASK))    rdata_o = mask_i;
    else if (addr_i == ADDR_W'(OFS_SCRATCH)) rdata_o = scratch_i;
    else if (addr_i == ADDR_W'(OFS_STATUS))  rdata_o = status_i;
    else if (addr_i == ADDR_W'(OFS_COUNT))   rdata_o = cnt_i;
    else if (addr_i == ADDR_W'(OFS_CMP))     rdata_o = cmp_i;
  end
endmodule

// File: rtl/irq_timer_ctl.sv
module irq_timer_ctl
  import irq_timer_pkg::*;
#(
  parameter int          DATA_W    = 64,
  parameter int          ADDR_W    = 20,
  parameter int unsigned STEP      = 1000,
  parameter int          TIMER_BIT = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              tick_i,
  output logic              cpu_irq_o,
  output logic              timer_irq_o
);
  logic wr_mask, wr_set, wr_clr, wr_scr, wr_cnt, wr_cmp;
  logic [DATA_W-1:0] mask, status, cnt, cmp, scratch_q;

  assign wr_mask = bus_we_i && (bus_addr_i == ADDR_W'(OFS_MASK));
  assign wr_set  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_SET));
  assign wr_clr  = bus_we_i && ((bus_addr_i == ADDR_W'(OFS_CLR)) ||
                                (bus_addr_i == ADDR_W'(OFS_STATUS)));
  assign wr_scr  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_SCRATCH));
  assign wr_cnt  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_COUNT));
  assign wr_cmp  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CMP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     scratch_q <= '0;
    else if (wr_scr) scratch_q <= bus_wdata_i;
  end

  itc_status_unit #(.DATA_W(DATA_W)) u_status (
    .clk_i, .rst_ni,
    .wr_mask_i(wr_mask), .wr_set_i(wr_set), .wr_clr_i(wr_clr),
    .wdata_i(bus_wdata_i),
    .mask_o(mask), .status_o(status), .irq_o(cpu_irq_o)
  );

  itc_counter_unit #(.DATA_W(DATA_W), .STEP(STEP)) u_counter (
    .clk_i, .rst_ni, .tick_i,
    .wr_cnt_i(wr_cnt), .wr_cmp_i(wr_cmp), .wdata_i(bus_wdata_i),
    .gate_i(mask[TIMER_BIT]),
    .cnt_o(cnt), .cmp_o(cmp), .irq_o(timer_irq_o)
  );

  itc_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rmux (
    .addr_i(bus_addr_i), .mask_i(mask), .status_i(status),
    .scratch_i(scratch_q), .cnt_i(cnt), .cmp_i(cmp), .rdata_o(bus_rdata_o)
  );

  // R10: scratch holds without a write
  a_r10_scratch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_scr |=> $stable(scratch_q));
  // R5: no interrupt with nothing pending under the mask
  a_r5_irq_needs_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> (status & mask) != '0);
  // R1: outputs quiet right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> !cpu_irq_o && !timer_irq_o);
endmodule

// File: tb/test_irq_timer_ctl.sv
module test_irq_timer_ctl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        tick = 1'b0;
  logic        cpu_irq, timer_irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_timer_ctl i_irq_timer_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick),
    .cpu_irq_o(cpu_irq), .timer_irq_o(timer_irq)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [63:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [19:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] exp_st;
    repeat (3) @(negedge clk);
    // R1: state during reset
    rd(20'h10000, v); chk("R1 mask in reset", v, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(20'h10000, v); chk("R1 mask", v, 0);
    rd(20'h10030, v); chk("R1 status", v, 0);
    rd(20'h20000, v); chk("R1 counter", v, 0);
    rd(20'h30000, v); chk("R1 compare", v, 0);
    rd(20'h10018, v); chk("R1 scratch", v, 0);
    chk("R1 irq lines", {62'd0, cpu_irq, timer_irq}, 0);

    // R9 constant and ignored write
    rd(20'h00020, v); chk("R9 memcfg", v, 64'h8001_0000);
    wr(20'h00020, 64'hFFFF);
    rd(20'h00020, v); chk("R9 memcfg after write", v, 64'h8001_0000);

    // R2 / R10 readback of patterns
    wr(20'h10000, 64'hA5A5_0000_1234_5678);
    rd(20'h10000, v); chk("R2 mask", v, 64'hA5A5_0000_1234_5678);
    wr(20'h10018, 64'hDEAD_BEEF_0000_0001);
    rd(20'h10018, v); chk("R10 scratch", v, 64'hDEAD_BEEF_0000_0001);
    wr(20'h10018, 64'h1);
    rd(20'h10018, v); chk("R10 scratch rewrite", v, 64'h1);

    // R3 replace, not OR
    wr(20'h10020, 64'hF0);
    wr(20'h10020, 64'h0F);
    rd(20'h10030, v); chk("R3 status replace", v, 64'h0F);
    // R4 clears through both addresses
    wr(20'h10020, 64'hFF00_FF00);
    wr(20'h10028, 64'h0F00_0F00);
    rd(20'h10030, v); chk("R4 clear via 0x10028", v, 64'hF000_F000);
    wr(20'h10030, 64'h1000_0000);
    rd(20'h10030, v); chk("R4 clear via 0x10030", v, 64'hE000_F000);

    // R5 sweep of single bits of status against mask
    for (int i = 0; i < 64; i++) begin
      for (int s = 0; s < 2; s++) begin
        int j = (i + s) % 64;
        wr(20'h10000, 64'd1 << j);
        wr(20'h10020, 64'd1 << i);
        chk($sformatf("R5 irq s%0d m%0d", i, j), {63'd0, cpu_irq}, {63'd0, i == j});
      end
    end
    exp_st = 64'h8000_0000_0000_0001;
    wr(20'h10000, 64'h1);
    wr(20'h10020, exp_st);
    chk("R5 irq on", {63'd0, cpu_irq}, 1);
    wr(20'h10028, 64'h1);
    chk("R5 irq after clear", {63'd0, cpu_irq}, 0);

    // R6 counter stepping
    wr(20'h20000, 64'd7);
    ticks(5);
    rd(20'h20000, v); chk("R6 five ticks", v, 64'd5007);
    wr(20'h20000, 64'hFFFF_FFFF_FFFF_FFFF);
    ticks(1);
    rd(20'h20000, v); chk("R6 wrap", v, 64'd999);

    // R7 write coinciding with tick
    @(negedge clk); addr = 20'h20000; wdata = 64'd42; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(20'h20000, v); chk("R7 write wins", v, 64'd42);

    // R8 compare and timer line
    wr(20'h30000, 64'd3500);
    rd(20'h30000, v); chk("R8 compare readback", v, 64'd3500);
    wr(20'h20000, 64'd0);
    wr(20'h10000, 64'd1 << 50);
    for (int k = 1; k <= 4; k++) begin
      ticks(1);
      chk($sformatf("R8 timer after %0d ticks", k), {63'd0, timer_irq},
          {63'd0, (k * 1000) > 3500});
    end
    wr(20'h10000, 64'd0);
    chk("R8 timer masked off", {63'd0, timer_irq}, 0);
    wr(20'h10000, 64'd1 << 50);
    wr(20'h30000, 64'd4000);
    chk("R8 timer at equal", {63'd0, timer_irq}, 0);
    wr(20'h30000, 64'd3999);
    chk("R8 timer just past", {63'd0, timer_irq}, 1);

    // R11 unmapped offsets
    wr(20'h10020, 64'h55);
    rd(20'h10020, v); chk("R11 set offset reads zero", v, 0);
    rd(20'h10028, v); chk("R11 clear offset reads zero", v, 0);
    rd(20'h00040, v); chk("R11 unmapped read", v, 0);
    wr(20'h00040, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(20'h10008, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(20'h20008, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(20'h10000, v); chk("R11 mask untouched", v, 64'd1 << 50);
    rd(20'h10030, v); chk("R11 status untouched", v, 64'h55);
    rd(20'h20000, v); chk("R11 counter untouched", v, 64'd4000);
    rd(20'h30000, v); chk("R11 compare untouched", v, 64'd3999);
    rd(20'h10018, v); chk("R11 scratch untouched", v, 64'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule